// File: doc/BRIEF.md
# Sync-loaded row select shift register

The block drives the row-select lines of a pixel array. At most one of its select outputs is active at a time. A start row is programmed through a small write port and held in a register. A row-sync pulse that is properly framed against the row clock loads the selection at that start row. Each later rising edge of the row clock then hands the active select on to the next row. When the last row has been passed, all selects go low until the next good sync.

The row clock and the row sync are level inputs. They are sampled on the system clock and are taken to be synchronous to it. A sync pulse is well framed when it stays high across exactly one rising edge of the row clock. The block judges this on the system-clock cycle in which the sync falls. A sync pulse that spans no rising edge, or more than one, leaves the selection untouched. It also raises a sticky error flag, which only reset clears. Alongside the one-hot vector the block reports the current row index and a flag that says whether any row is selected.

Top module: `row_select_sr`

## Requirements
- R1: While reset is high and on the first cycle after it, `sel_o` is all zero and `row_valid_o` and `sync_err_o` are 0.
- R2: A rising edge of the row clock is a cycle in which `row_clk_i` is 1 and was 0 in the cycle before. A sync pulse that covers exactly one such edge is valid. One cycle after the sync falls, `row_idx_o` equals the start register, `sel_o` has only bit `row_idx_o` set, and `row_valid_o` is 1.
- R3: While a row is selected and `row_sync_i` is low (and did not just fall), each rising edge moves the selection to the next row, one cycle later. With no rising edge and no sync fall, `sel_o` and `row_idx_o` hold.
- R4: A rising edge while row NROWS-1 is selected clears every select and drops `row_valid_o`. Further edges leave `sel_o` all zero until a valid sync.
- R5: A sync pulse that covers zero rising edges, or two or more, sets `sync_err_o` one cycle after its fall. The flag then stays 1 until reset, and such a sync does not change `sel_o` or `row_idx_o`.
- R6: Rising edges that occur while `row_sync_i` is high never move the selection.
- R7: `start_wr_i` with `start_row_i` writes the start register. The new value is used only by the next valid sync: it does not move a selection in progress. A write in the same cycle as a loading sync fall is not used by that load.
- R8: A valid sync with a start value of NROWS or more leaves `sel_o` all zero and `row_valid_o` at 0.
- R9: A rising edge in the same cycle as a valid sync's fall is not an advance. The load wins, and the start row is selected.
- R10: `sel_o` has at most one bit set, and it equals a one-hot decode of `row_idx_o` when `row_valid_o` is 1 and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| row_clk_i | input | 1 | Row clock level, sampled on clk |
| row_sync_i | input | 1 | Row sync level, sampled on clk |
| start_wr_i | input | 1 | Write enable of the start-row register |
| start_row_i | input | ADDR_W | Start-row value to write |
| sel_o | output | NROWS | One-hot row selects |
| row_idx_o | output | ADDR_W | Index of the selected row (meaningful while row_valid_o is 1) |
| row_valid_o | output | 1 | A row is selected |
| sync_err_o | output | 1 | Sticky flag for a badly framed sync |

## Verification
On every cycle the assertions check four things: the select vector against the index, single-step advance, the clear after the last row, and the freeze while sync is high. They also check that the error flag, once set, stays set and that the selection holds when there is neither an edge nor a sync fall. Other behaviours can only be shown by the bench's scenarios against its own model: that a load lands on the programmed row, which register value a load uses when a write races it, how a start row beyond the array is handled, and which sync shapes count as badly framed.

// File: rtl/rs_pkg.sv
package rs_pkg;

    // Edge events derived from the sampled row clock and row sync
    typedef struct packed {
        logic rise;        // row clock rising edge this cycle
        logic sync_hi;     // sync level this cycle
        logic sync_start;  // sync went high this cycle
        logic sync_fall;   // sync went low this cycle
    } edge_ev_t;

    // Outcome of a finished sync pulse
    typedef struct packed {
        logic load;        // well framed: load the start row
        logic bad;         // badly framed: flag it
    } frame_ev_t;

    // Number of row-clock edges seen inside the current sync pulse
    typedef enum logic [1:0] {
        CNT_NONE = 2'd0,
        CNT_ONE  = 2'd1,
        CNT_MANY = 2'd2
    } edge_cnt_e;

    function automatic edge_cnt_e cnt_bump(input edge_cnt_e c);
        case (c)
            CNT_NONE: return CNT_ONE;
            default:  return CNT_MANY;
        endcase
    endfunction

endpackage

// File: rtl/rs_edge_detect.sv
module rs_edge_detect
    import rs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     row_clk_i,
    input  logic     row_sync_i,
    output edge_ev_t ev_o
);

    logic rclk_q;
    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rclk_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            rclk_q <= row_clk_i;
            sync_q <= row_sync_i;
        end
    end

    always_comb begin
        ev_o.rise       = row_clk_i & ~rclk_q;
        ev_o.sync_hi    = row_sync_i;
        ev_o.sync_start = row_sync_i & ~sync_q;
        ev_o.sync_fall  = ~row_sync_i & sync_q;
    end

endmodule

// File: rtl/rs_sync_framer.sv
module rs_sync_framer
    import rs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  edge_ev_t  ev_i,
    output frame_ev_t fev_o,
    output logic      err_o
);

    edge_cnt_e cnt_q;
    edge_cnt_e cnt_d;
    logic      err_q;

    // Count rising edges seen while sync is high; a new pulse restarts it
    always_comb begin
        cnt_d = cnt_q;
        if (ev_i.sync_start) begin
            cnt_d = ev_i.rise ? CNT_ONE : CNT_NONE;
        end else if (ev_i.sync_hi && ev_i.rise) begin
            cnt_d = cnt_bump(cnt_q);
        end
    end

    always_comb begin
        fev_o.load = ev_i.sync_fall && (cnt_q == CNT_ONE);
        fev_o.bad  = ev_i.sync_fall && (cnt_q != CNT_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_NONE;
            err_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (fev_o.bad) begin
                err_q <= 1'b1;
            end
        end
    end

    assign err_o = err_q;

endmodule

// File: rtl/rs_start_reg.sv
module rs_start_reg #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] data_i,
    output logic [ADDR_W-1:0] start_o
);

    logic [ADDR_W-1:0] start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
        end else if (wr_i) begin
            start_q <= data_i;
        end
    end

    assign start_o = start_q;

endmodule

// File: rtl/rs_row_chain.sv
module rs_row_chain
    import rs_pkg::*;
#(
    parameter int unsigned NROWS  = 1024,
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  edge_ev_t          ev_i,
    input  frame_ev_t         fev_i,
    input  logic [ADDR_W-1:0] start_i,
    output logic [NROWS-1:0]  sel_o,
    output logic [ADDR_W-1:0] idx_o,
    output logic              valid_o
);

    localparam logic [ADDR_W:0]   ROWS_EXT = (ADDR_W+1)'(NROWS);
    localparam logic [ADDR_W-1:0] LAST_ROW = ADDR_W'(NROWS - 1);

    logic [NROWS-1:0]  sel_q;
    logic [NROWS-1:0]  load_vec;
    logic [ADDR_W-1:0] idx_q;
    logic              valid_q;
    logic              start_in_range;
    logic              advance;

    assign start_in_range = {1'b0, start_i} < ROWS_EXT;

    // One-hot decode of the start row, one comparator per select line
    for (genvar g = 0; g < NROWS; g++) begin : g_dec
        assign load_vec[g] = (start_i == ADDR_W'(g));
    end

    assign advance = ev_i.rise && !ev_i.sync_hi && !ev_i.sync_fall && valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            idx_q   <= '0;
            valid_q <= 1'b0;
        end else if (fev_i.load) begin
            sel_q   <= load_vec;
            idx_q   <= start_i;
            valid_q <= start_in_range;
        end else if (advance) begin
            sel_q <= sel_q << 1;
            if (idx_q == LAST_ROW) begin
                valid_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign sel_o   = sel_q;
    assign idx_o   = idx_q;
    assign valid_o = valid_q;

endmodule

// File: rtl/row_select_sr.sv
module row_select_sr
    import rs_pkg::*;
#(
    parameter int unsigned NROWS  = 1024,
    parameter int unsigned ADDR_W = $clog2(NROWS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              row_clk_i,
    input  logic              row_sync_i,
    input  logic              start_wr_i,
    input  logic [ADDR_W-1:0] start_row_i,
    output logic [NROWS-1:0]  sel_o,
    output logic [ADDR_W-1:0] row_idx_o,
    output logic              row_valid_o,
    output logic              sync_err_o
);

    edge_ev_t          ev;
    frame_ev_t         fev;
    logic [ADDR_W-1:0] start_row;

    rs_edge_detect u_edge (
        .clk        (clk),
        .rst        (rst),
        .row_clk_i  (row_clk_i),
        .row_sync_i (row_sync_i),
        .ev_o       (ev)
    );

    rs_sync_framer u_framer (
        .clk   (clk),
        .rst   (rst),
        .ev_i  (ev),
        .fev_o (fev),
        .err_o (sync_err_o)
    );

    rs_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (start_wr_i),
        .data_i  (start_row_i),
        .start_o (start_row)
    );

    rs_row_chain #(.NROWS(NROWS), .ADDR_W(ADDR_W)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (ev),
        .fev_i   (fev),
        .start_i (start_row),
        .sel_o   (sel_o),
        .idx_o   (row_idx_o),
        .valid_o (row_valid_o)
    );

endmodule

// File: rtl/row_select_sr_chk.sv
module row_select_sr_chk #(
    parameter int unsigned NROWS  = 1024,
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              row_clk_i,
    input logic              row_sync_i,
    input logic              start_wr_i,
    input logic [ADDR_W-1:0] start_row_i,
    input logic [NROWS-1:0]  sel_o,
    input logic [ADDR_W-1:0] row_idx_o,
    input logic              row_valid_o,
    input logic              sync_err_o
);

    localparam logic [ADDR_W-1:0] LAST_ROW = ADDR_W'(NROWS - 1);

    logic             rclk_p;
    logic             sync_p;
    logic             rise;
    logic [NROWS-1:0] exp_sel;
    logic             unused_ok;

    assign unused_ok = start_wr_i ^ (^start_row_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            rclk_p <= 1'b0;
            sync_p <= 1'b0;
        end else begin
            rclk_p <= row_clk_i;
            sync_p <= row_sync_i;
        end
    end

    assign rise = row_clk_i && !rclk_p;

    always_comb begin
        exp_sel = '0;
        for (int i = 0; i < NROWS; i++) begin
            if (row_valid_o && (row_idx_o == ADDR_W'(i))) exp_sel[i] = 1'b1;
        end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_o)) else $error("select not one-hot"); // R10

    AST_SEL_MATCH_IDX: assert property (@(posedge clk) disable iff (rst)
        sel_o == exp_sel) else $error("select disagrees with index"); // R10

    AST_STEP_NEXT_ROW: assert property (@(posedge clk) disable iff (rst)
        (rise && !row_sync_i && !sync_p && row_valid_o && row_idx_o != LAST_ROW)
        |=> (row_valid_o && row_idx_o == ADDR_W'($past(row_idx_o) + 1'b1)))
        else $error("advance did not step one row"); // R3

    AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
        (!rise && !(sync_p && !row_sync_i)) |=> $stable(sel_o))
        else $error("selection moved without event"); // R3

    AST_CLEAR_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (rise && !row_sync_i && !sync_p && row_valid_o && row_idx_o == LAST_ROW)
        |=> (!row_valid_o && sel_o == '0))
        else $error("last row not cleared"); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        sync_err_o |=> sync_err_o) else $error("error flag dropped"); // R5

    AST_FROZEN_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
        row_sync_i |=> $stable(sel_o)) else $error("selection moved during sync"); // R6

endmodule

bind row_select_sr row_select_sr_chk #(.NROWS(NROWS), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/row_select_sr_tb_top.sv
module row_select_sr_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          row_clk_i = 1'b0;
    logic          row_sync_i = 1'b0;
    logic          start_wr_i = 1'b0;
    logic [AW-1:0] start_row_i = '0;
    logic [N-1:0]  sel_o;
    logic [AW-1:0] row_idx_o;
    logic          row_valid_o;
    logic          sync_err_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 0;

    // behavioural reference state
    int m_idx = 0, m_start = 0, m_cnt = 0;
    bit m_valid = 0, m_err = 0, m_prc = 0, m_psy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    row_select_sr #(.NROWS(N), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .row_clk_i(row_clk_i), .row_sync_i(row_sync_i),
        .start_wr_i(start_wr_i), .start_row_i(start_row_i), .sel_o(sel_o),
        .row_idx_o(row_idx_o), .row_valid_o(row_valid_o), .sync_err_o(sync_err_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        end
    endtask

    function automatic longint exp_sel();
        return m_valid ? (longint'(1) << m_idx) : 0;
    endfunction

    // reference model step, applied at each rising clk edge
    task automatic model_step();
        bit rise, sfall, sstart;
        if (rst) begin
            m_idx = 0; m_start = 0; m_cnt = 0; m_valid = 0; m_err = 0; m_prc = 0; m_psy = 0;
            return;
        end
        rise   = row_clk_i && !m_prc;
        sstart = row_sync_i && !m_psy;
        sfall  = !row_sync_i && m_psy;
        if (sfall) begin
            if (m_cnt == 1) begin
                m_idx = m_start;
                m_valid = (m_start < N);
            end else m_err = 1;
        end else if (rise && !row_sync_i && m_valid) begin
            if (m_idx == N-1) m_valid = 0;
            else m_idx++;
        end
        if (sstart) m_cnt = rise ? 1 : 0;
        else if (row_sync_i && rise && m_cnt < 2) m_cnt++;
        if (start_wr_i) m_start = int'(start_row_i);
        m_prc = row_clk_i;
        m_psy = row_sync_i;
    endtask

    // one clk cycle: inputs already driven; update model at edge, compare after it
    task automatic tick();
        @(posedge clk);
        model_step();
        #(CLK_PERIOD/4);
        check("R10 sel vs model (R2/R3/R4/R6)", longint'(sel_o), exp_sel());
        check("R2 valid vs model", longint'(row_valid_o), longint'(m_valid));
        if (m_valid) check("R3 idx vs model", longint'(row_idx_o), longint'(m_idx));
        check("R5 err vs model", longint'(sync_err_o), longint'(m_err));
        start_wr_i = 1'b0;
    endtask

    task automatic drive(input bit rc, input bit sy);
        row_clk_i = rc;
        row_sync_i = sy;
        tick();
    endtask

    task automatic write_start(input int v);
        start_wr_i = 1'b1;
        start_row_i = AW'(v);
        tick();
    endtask

    // sync pulse covering the given number of row-clock rising edges
    task automatic sync_pulse(input int edges);
        drive(0, 1);
        for (int k = 0; k < edges; k++) begin
            drive(1, 1);
            drive(1, 1);
            drive(0, 1);
        end
        drive(0, 0);
    endtask

    task automatic row_pulse();
        drive(1, 0);
        drive(1, 0);
        drive(0, 0);
        drive(0, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive(0, 0);
        drive(0, 0);
        rst = 1'b0;
        drive(0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        do_reset();
        check("R1 sel after reset", longint'(sel_o), 0);
        check("R1 valid after reset", longint'(row_valid_o), 0);
        check("R1 err after reset", longint'(sync_err_o), 0);

        write_start(3);
        sync_pulse(1);
        check("R2 load idx", longint'(row_idx_o), 3);
        check("R2 load sel", longint'(sel_o), longint'(1) << 3);

        row_pulse();
        row_pulse();
        check("R3 two advances", longint'(row_idx_o), 5);
        for (int k = 0; k < 5; k++) drive(0, 0);
        check("R3 hold without edge", longint'(sel_o), longint'(1) << 5);

        write_start(14);
        row_pulse();
        check("R7 write does not move selection", longint'(row_idx_o), 6);

        sync_pulse(1);
        check("R7 new start used", longint'(row_idx_o), 14);
        row_pulse();
        check("R4 last row reached", longint'(sel_o), longint'(1) << 15);
        row_pulse();
        check("R4 cleared after last", longint'(sel_o), 0);
        check("R4 valid low after last", longint'(row_valid_o), 0);
        row_pulse();
        check("R4 stays clear", longint'(sel_o), 0);

        write_start(7);
        sync_pulse(1);
        check("R2 reload after clear", longint'(row_idx_o), 7);
        sync_pulse(0);
        check("R5 zero-edge sync flags", longint'(sync_err_o), 1);
        check("R5 zero-edge sync keeps row", longint'(row_idx_o), 7);
        for (int k = 0; k < 4; k++) row_pulse();
        check("R5 error sticky", longint'(sync_err_o), 1);

        do_reset();
        write_start(2);
        sync_pulse(1);
        row_pulse();
        check("R3 at row 3", longint'(row_idx_o), 3);
        write_start(9);
        sync_pulse(2);
        check("R6 edges in sync do not advance", longint'(row_idx_o), 3);
        check("R5 two-edge sync flags", longint'(sync_err_o), 1);
        check("R5 two-edge sync keeps row", longint'(sel_o), longint'(1) << 3);

        write_start(20);
        sync_pulse(1);
        check("R8 out-of-range start selects none", longint'(sel_o), 0);
        check("R8 valid low", longint'(row_valid_o), 0);

        write_start(4);
        drive(0, 1);
        drive(1, 1);
        drive(0, 1);
        start_wr_i = 1'b1;
        start_row_i = AW'(11);
        drive(1, 0);
        check("R9 load wins over edge", longint'(row_idx_o), 4);
        check("R7 same-cycle write not used by load", longint'(sel_o), longint'(1) << 4);
        drive(0, 0);
        sync_pulse(1);
        check("R7 raced write used by next sync", longint'(row_idx_o), 11);

        report();
        $finish;
    end

endmodule